// File: doc/BRIEF.md
# SDRAM Write Burst Capture Engine

This block sits on the memory side of an SDRAM command bus and turns WRITE commands into a stream of per-beat column write strobes for a storage array. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable pins. When it sees a WRITE, it latches the bank and starting column and takes the data word present on that same edge as the first beat. From then on it produces one strobe, with bank, column and data, for each further edge until the burst is done.

The burst length is a static setting: 1, 2, 4 or 8 beats, or a full page that runs until something stops it. A new WRITE on any cycle cuts off the burst in progress. A BURST TERMINATE command also stops it. When address bit 10 is high on the WRITE and the burst runs to its natural end, the block raises a one-cycle auto-precharge request tagged with the bank. Every output is registered, so each strobe appears in the cycle after the edge that captured its data.

Top module: `sdram_wr_burst`

## Requirements
- R1: A WRITE (cs_n=0, ras_n=1, cas_n=0, we_n=0, sampled while cke=1) latches ba and addr[8:0]. In the next cycle wr_en=1, with wr_bank=ba, wr_col=addr[8:0] and wr_data equal to dq as sampled on the command edge.
- R2: bl_sel[2]=0 selects a fixed burst of 2^bl_sel[1:0] beats (1, 2, 4 or 8). bl_sel[2]=1 selects full page. Each beat after the first is strobed one cycle after the previous one and carries dq as sampled on its own edge.
- R3: Within a fixed burst the column advances by one inside the block that is aligned to the burst length. It wraps to the start of that block (for example 6,7,0,1... for a start column of 6 with 8 beats in the block at 0).
- R4: Once a fixed burst has delivered all its beats, wr_en stays 0 whatever dq does, until the next WRITE.
- R5: A full-page burst never ends by itself. The column after 511 is 0.
- R6: A WRITE on any cycle of a running burst ends that burst at once. The beat captured on that edge belongs to the new command. WRITEs on consecutive edges each produce exactly their own beats.
- R7: BURST TERMINATE (cs_n=0, ras_n=1, cas_n=1, we_n=0) stops a running burst. No strobe is produced for that edge or for any later edge.
- R8: When addr[10]=1 on the WRITE and the fixed burst reaches its last beat, ap_req=1 for exactly the cycle of that last strobe, and ap_bank equals the burst's bank. A burst with addr[10]=0, a truncated or terminated burst, or a full-page burst raises no request.
- R9: An edge with cke=0 produces no strobe and no request, ignores the command pins and leaves the burst position unchanged. The burst resumes on the next edge with cke=1.
- R10: Every other pin encoding, including cs_n=1, is a no-op and does not disturb a running burst.
- R11: During and straight after reset, wr_en=0, ap_req=0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low freezes the engine |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin |
| cas_n | input | 1 | Column strobe pin |
| we_n | input | 1 | Write-enable pin |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address; [8:0] column, [10] auto precharge |
| dq | input | 32 | Write data bus |
| bl_sel | input | 3 | Burst length select (static) |
| wr_en | output | 1 | Column write strobe |
| wr_bank | output | 2 | Bank of the current beat |
| wr_col | output | 9 | Column of the current beat |
| wr_data | output | 32 | Data of the current beat |
| ap_req | output | 1 | Auto-precharge request pulse |
| ap_bank | output | 2 | Bank to precharge |

## Verification
The bench cuts an 8-beat auto-precharge burst with a second WRITE at every beat position. A design that let a truncated burst keep its precharge, or that wrote one beat too many, would then show a stray ap_req or a column from the wrong stream. Full-page bursts start just below column 511, which exposes a counter that saturates or that wraps inside an aligned block. The bench also drives back-to-back WRITEs to different banks, lowers cke in the middle of a burst, and puts READ, ACTIVE and deselect cycles between beats. These catch an engine that drops the beat on the command edge, that advances while frozen, or that treats a foreign command as a stop.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_STOP  = 2'd2
    } sdw_cmd_e;

    // Beats of a fixed burst for the two low select bits: 1, 2, 4 or 8
    function automatic logic [3:0] fixed_beats(input logic [1:0] sel);
        return 4'd1 << sel;
    endfunction

endpackage

// File: rtl/sdw_cmd_decode.sv
module sdw_cmd_decode
    import sdw_pkg::*;
(
    input  logic     cke,
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output sdw_cmd_e cmd
);

    always_comb begin
        cmd = CMD_IDLE;
        if (cke && !cs_n && ras_n && !we_n) begin
            cmd = cas_n ? CMD_STOP : CMD_WRITE;
        end
    end

endmodule

// File: rtl/sdw_col_step.sv
module sdw_col_step #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] col_i,
    input  logic [2:0]       bl_sel_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] wrap_mask;
    logic [COL_W-1:0] col_inc;

    always_comb begin
        if (bl_sel_i[2]) begin
            wrap_mask = '1;
        end else begin
            wrap_mask = COL_W'((4'd1 << bl_sel_i[1:0]) - 4'd1);
        end
        col_inc = col_i + COL_W'(1);
        col_o   = (col_i & ~wrap_mask) | (col_inc & wrap_mask);
    end

endmodule

// File: rtl/sdram_wr_burst.sv
module sdram_wr_burst
    import sdw_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 13,
    parameter int COL_W  = 9,
    parameter int AP_BIT = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq,
    input  logic [2:0]        bl_sel,
    output logic              wr_en,
    output logic [BANK_W-1:0] wr_bank,
    output logic [COL_W-1:0]  wr_col,
    output logic [DATA_W-1:0] wr_data,
    output logic              ap_req,
    output logic [BANK_W-1:0] ap_bank
);

    localparam int CNT_W = 4;

    typedef struct packed {
        logic              active;
        logic              full;
        logic              ap_arm;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  ncol;
        logic [CNT_W-1:0]  left;
        logic              wen;
        logic [BANK_W-1:0] wbank;
        logic [COL_W-1:0]  wcol;
        logic [DATA_W-1:0] wdata;
        logic              ap;
        logic [BANK_W-1:0] apbank;
    } sdw_state_t;

    sdw_state_t       st_d, st_q;
    sdw_cmd_e         cmd;
    logic [COL_W-1:0] cmd_col;
    logic [COL_W-1:0] cmd_col_nxt;
    logic [COL_W-1:0] run_col_nxt;
    logic [CNT_W-1:0] beats;

    assign cmd_col = addr[COL_W-1:0];
    assign beats   = fixed_beats(bl_sel[1:0]);

    sdw_cmd_decode i_dec (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdw_col_step #(.COL_W(COL_W)) i_step_cmd (
        .col_i    (cmd_col),
        .bl_sel_i (bl_sel),
        .col_o    (cmd_col_nxt)
    );

    sdw_col_step #(.COL_W(COL_W)) i_step_run (
        .col_i    (st_q.ncol),
        .bl_sel_i (bl_sel),
        .col_o    (run_col_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.wen = 1'b0;
        st_d.ap  = 1'b0;
        if (cke) begin
            unique case (cmd)
                CMD_WRITE: begin
                    st_d.wen    = 1'b1;
                    st_d.wbank  = ba;
                    st_d.wcol   = cmd_col;
                    st_d.wdata  = dq;
                    st_d.bank   = ba;
                    st_d.ncol   = cmd_col_nxt;
                    st_d.full   = bl_sel[2];
                    st_d.left   = beats - CNT_W'(1);
                    st_d.ap_arm = addr[AP_BIT];
                    st_d.active = bl_sel[2] || (beats != CNT_W'(1));
                    if (!bl_sel[2] && beats == CNT_W'(1) && addr[AP_BIT]) begin
                        st_d.ap     = 1'b1;
                        st_d.apbank = ba;
                    end
                end
                CMD_STOP: begin
                    st_d.active = 1'b0;
                end
                default: begin
                    if (st_q.active) begin
                        st_d.wen   = 1'b1;
                        st_d.wbank = st_q.bank;
                        st_d.wcol  = st_q.ncol;
                        st_d.wdata = dq;
                        st_d.ncol  = run_col_nxt;
                        if (!st_q.full) begin
                            st_d.left = st_q.left - CNT_W'(1);
                            if (st_q.left == CNT_W'(1)) begin
                                st_d.active = 1'b0;
                                st_d.ap     = st_q.ap_arm;
                                st_d.apbank = st_q.bank;
                            end
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en   = st_q.wen;
    assign wr_bank = st_q.wbank;
    assign wr_col  = st_q.wcol;
    assign wr_data = st_q.wdata;
    assign ap_req  = st_q.ap;
    assign ap_bank = st_q.apbank;

endmodule

// File: rtl/sdw_chk.sv
module sdw_chk #(
    parameter int BANK_W = 2,
    parameter int COL_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BANK_W-1:0] ba,
    input logic [COL_W-1:0]  addr_col,
    input logic              bl_sel_full,
    input logic              wr_en,
    input logic [BANK_W-1:0] wr_bank,
    input logic [COL_W-1:0]  wr_col,
    input logic              ap_req,
    input logic [BANK_W-1:0] ap_bank
);

    logic is_wr, is_stop;
    assign is_wr   = cke && !cs_n && ras_n && !cas_n && !we_n;
    assign is_stop = cke && !cs_n && ras_n && cas_n && !we_n;

    // R1
    write_beat0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |=> (wr_en && wr_bank == $past(ba) && wr_col == $past(addr_col)));

    // R7
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_stop |=> !wr_en);

    // R9
    frozen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> (!wr_en && !ap_req));

    // R8
    ap_with_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req |-> (wr_en && ap_bank == wr_bank));

    // R5
    page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && $past(bl_sel_full) && !$past(is_wr)
         && $past(wr_col) == {COL_W{1'b1}}) |-> (wr_col == '0));

endmodule

bind sdram_wr_burst sdw_chk #(.BANK_W(BANK_W), .COL_W(COL_W)) i_sdw_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cke         (cke),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .ba          (ba),
    .addr_col    (addr[COL_W-1:0]),
    .bl_sel_full (bl_sel[2]),
    .wr_en       (wr_en),
    .wr_bank     (wr_bank),
    .wr_col      (wr_col),
    .ap_req      (ap_req),
    .ap_bank     (ap_bank)
);

// File: tb/test_sdram_wr_burst.sv
module test_sdram_wr_burst;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [31:0] dq = 32'h1000_0000;
    logic [2:0]  bl_sel = 3'd0;
    logic        wr_en, ap_req;
    logic [1:0]  wr_bank, ap_bank;
    logic [8:0]  wr_col;
    logic [31:0] wr_data;

    int    n_chk = 0, n_bad = 0;
    string cur_req = "R11";
    bit    cmp_on = 1'b0;

    // Reference model state
    bit          m_act, m_full, m_ap;
    int          m_bank, m_col, m_left, m_len;
    bit          e_en, e_ap;
    int          e_bank, e_col, e_apb;
    logic [31:0] e_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_wr_burst i_sdram_wr_burst (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dq(dq),
        .bl_sel(bl_sel), .wr_en(wr_en), .wr_bank(wr_bank), .wr_col(wr_col),
        .wr_data(wr_data), .ap_req(ap_req), .ap_bank(ap_bank)
    );

    function automatic int next_col(int c, int len);
        if (len == 0) return (c + 1) % 512;
        return c - (c % len) + ((c + 1) % len);
    endfunction

    always @(posedge clk) begin
        e_en = 1'b0;
        e_ap = 1'b0;
        if (!rst_n) begin
            m_act = 1'b0;
        end else if (cke) begin
            if (!cs_n && ras_n && !cas_n && !we_n) begin
                m_full = bl_sel[2];
                m_len  = bl_sel[2] ? 0 : (1 << bl_sel[1:0]);
                e_en = 1'b1; e_bank = ba; e_col = addr[8:0]; e_data = dq;
                m_bank = ba; m_ap = addr[10];
                m_col  = next_col(e_col, m_len);
                m_left = m_len - 1;
                m_act  = m_full || (m_len > 1);
                if (!m_full && m_len == 1 && m_ap) begin
                    e_ap = 1'b1; e_apb = ba;
                end
            end else if (!cs_n && ras_n && cas_n && !we_n) begin
                m_act = 1'b0;
            end else if (m_act) begin
                e_en = 1'b1; e_bank = m_bank; e_col = m_col; e_data = dq;
                m_col = next_col(m_col, m_len);
                if (!m_full) begin
                    m_left--;
                    if (m_left == 0) begin
                        m_act = 1'b0;
                        if (m_ap) begin e_ap = 1'b1; e_apb = m_bank; end
                    end
                end
            end
        end
    end

    task automatic check(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check("wr_en", int'(wr_en), int'(e_en));
            if (e_en && wr_en) begin
                check("wr_bank", int'(wr_bank), e_bank);
                check("wr_col", int'(wr_col), e_col);
                check("wr_data", int'(wr_data), int'(e_data));
            end
            check("ap_req", int'(ap_req), int'(e_ap));
            if (e_ap && ap_req) check("ap_bank", int'(ap_bank), e_apb);
        end
        dq <= dq + 32'h0101_0107;
    end

    task automatic pins(bit c, bit r, bit a, bit w);
        cs_n = c; ras_n = r; cas_n = a; we_n = w;
    endtask

    task automatic cmd_write(int b, int col, bit ap);
        pins(0, 1, 0, 0);
        ba = 2'(b);
        addr = 13'(col);
        addr[10] = ap;
        @(negedge clk);
        pins(1, 1, 1, 1);
    endtask

    task automatic cmd_raw(bit c, bit r, bit a, bit w);
        pins(c, r, a, w);
        @(negedge clk);
        pins(1, 1, 1, 1);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: idle outputs in reset
        check("reset wr_en", int'(wr_en), 0);
        check("reset ap_req", int'(ap_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("post-reset wr_en", int'(wr_en), 0);
        cmp_on = 1'b1;

        // R1 / R2 / R3 / R4 / R8: every fixed length, with and without precharge
        for (int s = 0; s < 4; s++) begin
            bl_sel = 3'(s);
            cur_req = "R1";
            cmd_write(s, 6 + 64 * s, 1'b0);
            idle(10);
            cur_req = "R3";
            cmd_write(3 - s, 13 + 32 * s, 1'b1);
            idle(10);
            cur_req = "R4";
            idle(4);
        end

        // R5 / R7: full page across column 511, then terminate
        bl_sel = 3'b100;
        cur_req = "R5";
        cmd_write(2, 506, 1'b1);
        idle(12);
        cur_req = "R7";
        cmd_raw(0, 1, 1, 0);
        idle(6);

        // R6 / R8: truncation at every beat of an 8-beat precharge burst
        bl_sel = 3'd3;
        for (int k = 1; k <= 8; k++) begin
            cur_req = "R6";
            cmd_write(0, 16, 1'b1);
            idle(k - 1);
            cur_req = "R8";
            cmd_write(1, 41, 1'b0);
            idle(10);
        end

        // R6: back-to-back writes to different banks
        bl_sel = 3'd2;
        cur_req = "R6";
        cmd_write(0, 4, 1'b1);
        cmd_write(1, 9, 1'b1);
        cmd_write(2, 14, 1'b0);
        cmd_write(3, 3, 1'b1);
        idle(8);

        // R7 / R8: terminated precharge burst raises nothing
        bl_sel = 3'd3;
        cur_req = "R7";
        cmd_write(1, 0, 1'b1);
        idle(2);
        cmd_raw(0, 1, 1, 0);
        idle(10);

        // R9: clock enable low mid-burst freezes position
        cur_req = "R9";
        cmd_write(2, 21, 1'b1);
        idle(2);
        cke = 1'b0;
        pins(0, 1, 0, 0);
        idle(3);
        pins(1, 1, 1, 1);
        cke = 1'b1;
        idle(10);

        // R10: foreign encodings inside a burst
        cur_req = "R10";
        cmd_write(3, 50, 1'b1);
        cmd_raw(0, 0, 1, 1);
        cmd_raw(0, 1, 0, 1);
        cmd_raw(1, 1, 0, 0);
        cmd_raw(0, 0, 0, 0);
        idle(10);

        summary();
    end

endmodule